// File: doc/BRIEF.md
# Sensor Register Access Slave for a Two-Wire Serial Bus

This block lets an external host on an I2C bus read and write a small register file that belongs to a light-measurement engine. It runs on a fast system clock that oversamples both bus wires. Each wire passes through a synchroniser and then an edge detector. The block recognises START, repeated START and STOP conditions. It answers only to a fixed 7-bit device address. The data line is pulled low through an open-drain output enable, and is otherwise released.

The register file has two read-write control bytes, which drive the measurement logic, and two read-only bytes that return the 16-bit conversion result. It also has an identification byte. That byte combines a fixed 3-bit identity code with a brownout flag. The flag is set at reset, and the host can only clear it.

After every data byte, the register pointer steps through the implemented addresses in order and wraps back to the first. A register write takes effect only once its data byte has been fully received and acknowledged. When a host write lands on an implemented register, the block gives the measurement logic a one-cycle strobe for that register.

Top module: `i2cs_sensor_regs`

## Requirements
- R1: After reset, both control outputs are 0x00, the brownout output is 1 and the data-line pull-down enable is 0.
- R2: An address byte whose upper seven bits are 1000100 is acknowledged, and its least significant bit selects read (1) or write (0). Bytes move most significant bit first, and an acknowledge is the data line held low through the ninth clock.
- R3: An address byte with any other 7-bit address is not acknowledged. The block then neither acknowledges nor writes anything until the next START.
- R4: A write transfer sends the address byte, then a pointer byte, then data bytes, and each of these is acknowledged. A data byte updates register 0x00 or 0x01 and produces one pulse on that register's strobe bit.
- R5: After each data byte, written or read, the pointer advances through the order 0x00, 0x01, 0x02, 0x03, 0x0F and then back to 0x00. Writes to 0x02 and 0x03 store nothing.
- R6: To read, the host writes the pointer, issues a repeated START and sends the address with the read bit set. The block then sends bytes for as long as the host acknowledges, and it stops driving after the host does not acknowledge.
- R7: A STOP that arrives in the middle of a data byte changes no register and produces no strobe. The next transfer works normally.
- R8: Register 0x0F reads as 0xA8 after reset. Its bits 5:3 are always 101, and bits 6 and 2:0 always read 0. Bit 7 is the brownout flag. Writing 0 to bit 7 clears it, and writing 1 never sets it.
- R9: An unimplemented pointer value reads as 0x00 and ignores writes, but its data bytes are still acknowledged. Any pointer value above 0x03 advances to 0x00.
- R10: The data line is only ever pulled low, and the block is not driving it after a STOP.
- R11: Register 0x02 returns bits 7:0 of the result input, and register 0x03 returns bits 15:8.
- R12: The strobe bits, in order from bit 0, belong to registers 0x00, 0x01, 0x02, 0x03 and 0x0F, and at most one bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock wire as seen at the pad |
| sda_i | input | 1 | Bus data wire as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls the data wire low; 0 releases it |
| mode_o | output | 8 | Contents of control register 0x00 |
| cfg_o | output | 8 | Contents of control register 0x01 |
| result_i | input | 16 | Conversion result shown at 0x02 (low byte) and 0x03 (high byte) |
| brownout_o | output | 1 | Brownout flag, bit 7 of 0x0F |
| wr_stb_o | output | 5 | One-cycle write strobe for each implemented register |

## Verification
Write transfers are exercised in four patterns: a single byte, a burst that crosses both read-only bytes and the identification byte and then wraps to 0x00, a transfer with a foreign address, and a data byte cut short by STOP. Comparing the control outputs and the strobe counts across these patterns separates a correct commit point, correct pointer advance and correct address filtering from an early commit or a missing wrap. Reads cover a burst starting at 0x02, which shows byte order, pointer advance and the host-NACK ending, and also reads from unimplemented addresses, which show both the zero fill and the wrap rule. Sequences on the identification byte separate a flag that can only be cleared from one that is a plain read-write bit.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam logic [BYTE_W-1:0] A_MODE = 8'h00;
   localparam logic [BYTE_W-1:0] A_CFG  = 8'h01;
   localparam logic [BYTE_W-1:0] A_RESL = 8'h02;
   localparam logic [BYTE_W-1:0] A_RESH = 8'h03;
   localparam logic [BYTE_W-1:0] A_IDST = 8'h0F;
   localparam int unsigned N_SLOTS = 5;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ADDR, ST_AACK, ST_PTR, ST_PACK,
      ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_SKIP
   } bus_st_e;

   // sparse pointer walk: 00,01,02,03,0F, then back to 00
   function automatic logic [BYTE_W-1:0] next_ptr(input logic [BYTE_W-1:0] a);
      if (a == A_RESH)     return A_IDST;
      else if (a > A_RESH) return A_MODE;
      else                 return a + 8'd1;
   endfunction
endpackage

// File: rtl/i2cs_sync.sv
`timescale 1ns/1ps
module i2cs_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("i2cs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cs_regfile.sv
`timescale 1ns/1ps
module i2cs_regfile
   import i2cs_pkg::*;
#(
   parameter logic [2:0] ID_CODE = 3'b101,
   parameter int unsigned RES_W  = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [BYTE_W-1:0]    wr_addr,
   input  logic [BYTE_W-1:0]    wr_data,
   input  logic [BYTE_W-1:0]    rd_addr,
   output logic [BYTE_W-1:0]    rd_data,
   input  logic [RES_W-1:0]     result_i,
   output logic [BYTE_W-1:0]    mode_o,
   output logic [BYTE_W-1:0]    cfg_o,
   output logic                 brownout_o,
   output logic [N_SLOTS-1:0]   wr_stb_o
);
   generate
      if (RES_W != 2*BYTE_W) begin : g_bad_w
         $error("i2cs_regfile: result must span exactly two bytes");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o     <= '0;
         cfg_o      <= '0;
         brownout_o <= 1'b1;
         wr_stb_o   <= '0;
      end else begin
         wr_stb_o <= '0;
         if (wr_en) begin
            case (wr_addr)
               A_MODE: begin mode_o <= wr_data; wr_stb_o <= 5'b00001; end
               A_CFG:  begin cfg_o  <= wr_data; wr_stb_o <= 5'b00010; end
               A_RESL: wr_stb_o <= 5'b00100;
               A_RESH: wr_stb_o <= 5'b01000;
               A_IDST: begin
                  brownout_o <= brownout_o & wr_data[BYTE_W-1];
                  wr_stb_o   <= 5'b10000;
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (rd_addr)
         A_MODE:  rd_data = mode_o;
         A_CFG:   rd_data = cfg_o;
         A_RESL:  rd_data = result_i[BYTE_W-1:0];
         A_RESH:  rd_data = result_i[RES_W-1:BYTE_W];
         A_IDST:  rd_data = {brownout_o, 1'b0, ID_CODE, 3'b000};
         default: rd_data = '0;
      endcase
   end

   p_mode_only_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != $past(mode_o)) |-> wr_stb_o[0]);
   p_cfg_only_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_o != $past(cfg_o)) |-> wr_stb_o[1]);
   p_bout_never_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(brownout_o) |-> !brownout_o);
   p_stb_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_stb_o));
endmodule

// File: rtl/i2cs_sensor_regs.sv
`timescale 1ns/1ps
module i2cs_sensor_regs
   import i2cs_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR    = 7'b1000100,
   parameter logic [2:0]  ID_CODE     = 3'b101,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RES_W       = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_pull_o,
   output logic [7:0]         mode_o,
   output logic [7:0]         cfg_o,
   input  logic [RES_W-1:0]   result_i,
   output logic               brownout_o,
   output logic [N_SLOTS-1:0] wr_stb_o
);
   localparam int unsigned LAST_BIT = BYTE_W;

   logic [1:0] pin_raw, pin_s;
   assign pin_raw = {scl_i, sda_i};

   generate
      for (genvar g = 0; g < 2; g++) begin : g_sync
         i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(pin_raw[g]), .q(pin_s[g]));
      end
   endgenerate

   logic scl_s, sda_s, scl_d, sda_d;
   assign scl_s = pin_s[1];
   assign sda_s = pin_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin scl_d <= 1'b1; sda_d <= 1'b1; end
      else        begin scl_d <= scl_s; sda_d <= sda_s; end
   end

   logic scl_rise, scl_fall, start_ev, stop_ev;
   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

   bus_st_e            st;
   logic [3:0]         cnt;
   logic [BYTE_W-1:0]  sh, tx, ptr, rd_data;
   logic               rw, mack;
   logic               wr_en;

   assign wr_en = (st == ST_WACK) && scl_fall;

   i2cs_regfile #(.ID_CODE(ID_CODE), .RES_W(RES_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr), .wr_data(sh),
      .rd_addr(ptr), .rd_data(rd_data), .result_i(result_i),
      .mode_o(mode_o), .cfg_o(cfg_o), .brownout_o(brownout_o),
      .wr_stb_o(wr_stb_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0; ptr <= '0;
         rw <= 1'b0; mack <= 1'b0; sda_pull_o <= 1'b0;
      end else if (start_ev) begin
         st <= ST_ADDR; cnt <= '0; sda_pull_o <= 1'b0;
      end else if (stop_ev) begin
         st <= ST_IDLE; cnt <= '0; sda_pull_o <= 1'b0;
      end else begin
         case (st)
            ST_ADDR, ST_PTR, ST_WDAT: begin
               if (scl_rise) begin
                  sh  <= {sh[BYTE_W-2:0], sda_s};
                  cnt <= cnt + 4'd1;
               end else if (scl_fall && cnt == LAST_BIT[3:0]) begin
                  cnt <= '0;
                  if (st == ST_ADDR) begin
                     if (sh[7:1] == DEV_ADDR) begin
                        rw <= sh[0]; sda_pull_o <= 1'b1; st <= ST_AACK;
                     end else begin
                        st <= ST_SKIP;
                     end
                  end else begin
                     sda_pull_o <= 1'b1;
                     st <= (st == ST_PTR) ? ST_PACK : ST_WACK;
                  end
               end
            end
            ST_AACK: if (scl_fall) begin
               if (rw) begin
                  tx <= rd_data; sda_pull_o <= ~rd_data[BYTE_W-1]; st <= ST_RDAT;
               end else begin
                  sda_pull_o <= 1'b0; st <= ST_PTR;
               end
            end
            ST_PACK: if (scl_fall) begin
               sda_pull_o <= 1'b0; ptr <= sh; st <= ST_WDAT;
            end
            ST_WACK: if (scl_fall) begin
               sda_pull_o <= 1'b0; ptr <= next_ptr(ptr); st <= ST_WDAT;
            end
            ST_RDAT: begin
               if (scl_rise) cnt <= cnt + 4'd1;
               else if (scl_fall) begin
                  if (cnt == LAST_BIT[3:0]) begin
                     cnt <= '0; sda_pull_o <= 1'b0; mack <= 1'b0;
                     ptr <= next_ptr(ptr); st <= ST_RACK;
                  end else begin
                     tx <= {tx[BYTE_W-2:0], 1'b0};
                     sda_pull_o <= ~tx[BYTE_W-2];
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) mack <= ~sda_s;
               else if (scl_fall) begin
                  if (mack) begin
                     tx <= rd_data; sda_pull_o <= ~rd_data[BYTE_W-1]; st <= ST_RDAT;
                  end else begin
                     st <= ST_SKIP;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   p_stop_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> (st == ST_IDLE && !sda_pull_o));
   p_skip_is_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SKIP) |-> !sda_pull_o);
   p_pull_only_when_owned_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sda_pull_o |-> (st == ST_AACK || st == ST_PACK || st == ST_WACK || st == ST_RDAT));
   p_pull_steady_scl_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && scl_d) |=> $stable(sda_pull_o));
endmodule

// File: tb/tb_i2cs_sensor_regs.sv
`timescale 1ns/1ps
module tb_i2cs_sensor_regs;
   localparam time TCLK = 8ns;
   localparam time Q    = 80ns;

   logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
   logic sda_line, sda_pull;
   logic [7:0] mode, cfg;
   logic [15:0] result = 16'h0000;
   logic bout;
   logic [4:0] stb;
   int checks = 0, errors = 0;
   int stb_cnt [5];

   always #(TCLK/2) clk = ~clk;
   assign sda_line = m_sda & ~sda_pull;

   i2cs_sensor_regs dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_pull_o(sda_pull), .mode_o(mode), .cfg_o(cfg), .result_i(result),
      .brownout_o(bout), .wr_stb_o(stb));

   initial for (int i = 0; i < 5; i++) stb_cnt[i] = 0;
   always @(posedge clk) for (int i = 0; i < 5; i++) if (stb[i]) stb_cnt[i]++;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      m_sda = 1'b1; #Q; scl = 1'b1; #Q; m_sda = 1'b0; #Q; scl = 1'b0; #Q;
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; #Q; scl = 1'b1; #Q; m_sda = 1'b1; #Q;
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_sda = b[i]; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
      end
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      m_sda = 1'b1; #Q; scl = 1'b1; #Q; ack = ~sda_line; #Q; scl = 1'b0; #Q;
   endtask

   task automatic rd_byte(input logic host_ack, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         #Q; scl = 1'b1; #Q; b[i] = sda_line; #Q; scl = 1'b0;
      end
      #Q; m_sda = ~host_ack; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q; m_sda = 1'b1;
   endtask

   task automatic set_ptr(input logic [7:0] p, input string req);
      logic a;
      bus_start();
      wr_byte(8'h88, a); check({req, " addr ack"}, a, 1'b1);
      wr_byte(p, a);     check({req, " ptr ack"}, a, 1'b1);
   endtask

   task automatic t_reset();
      check("R1 mode", mode, 8'h00);
      check("R1 cfg", cfg, 8'h00);
      check("R1 brownout", bout, 1'b1);
      check("R10 released", sda_pull, 1'b0);
   endtask

   task automatic t_id_read();
      logic a; logic [7:0] d;
      set_ptr(8'h0F, "R2");
      bus_start(); wr_byte(8'h89, a); check("R2 read addr ack", a, 1'b1);
      rd_byte(1'b0, d); check("R8 id reset value", d, 8'hA8);
      bus_stop(); #(4*TCLK);
      check("R10 released after stop", sda_pull, 1'b0);
   endtask

   task automatic t_single_write();
      logic a; int s0;
      s0 = stb_cnt[0];
      set_ptr(8'h00, "R4");
      wr_byte(8'h5A, a); check("R4 data ack", a, 1'b1);
      bus_stop(); #(4*TCLK);
      check("R4 mode written", mode, 8'h5A);
      check("R4 one strobe", stb_cnt[0] - s0, 1);
   endtask

   task automatic t_bad_addr();
      logic a;
      bus_start();
      wr_byte(8'h8A, a); check("R3 foreign addr nack", a, 1'b0);
      wr_byte(8'h00, a); check("R3 ptr ignored", a, 1'b0);
      wr_byte(8'h11, a); check("R3 data ignored", a, 1'b0);
      bus_stop(); #(4*TCLK);
      check("R3 mode unchanged", mode, 8'h5A);
   endtask

   task automatic t_burst_write();
      logic a; int acks = 0; int s2, s3, s4;
      logic [7:0] dat [5] = '{8'h11, 8'h22, 8'h33, 8'h7F, 8'h99};
      s2 = stb_cnt[2]; s3 = stb_cnt[3]; s4 = stb_cnt[4];
      set_ptr(8'h01, "R5");
      for (int i = 0; i < 5; i++) begin wr_byte(dat[i], a); acks += int'(a); end
      bus_stop(); #(4*TCLK);
      check("R5 all data acked", acks, 5);
      check("R5 cfg first", cfg, 8'h11);
      check("R5 wrapped to mode", mode, 8'h99);
      check("R8 brownout cleared", bout, 1'b0);
      check("R12 ro strobes", (stb_cnt[2]-s2) + (stb_cnt[3]-s3), 2);
      check("R12 id strobe", stb_cnt[4] - s4, 1);
   endtask

   task automatic t_bout_no_set();
      logic a; logic [7:0] d;
      set_ptr(8'h0F, "R8");
      wr_byte(8'hFF, a);
      bus_stop(); #(4*TCLK);
      check("R8 cannot set", bout, 1'b0);
      set_ptr(8'h0F, "R8");
      bus_start(); wr_byte(8'h89, a); rd_byte(1'b0, d); bus_stop();
      check("R8 id fixed bits", d, 8'h28);
   endtask

   task automatic t_burst_read();
      logic a; logic [7:0] d;
      result = 16'hBEEF;
      set_ptr(8'h02, "R6");
      bus_start(); wr_byte(8'h89, a); check("R6 read addr ack", a, 1'b1);
      rd_byte(1'b1, d); check("R11 low byte", d, 8'hEF);
      rd_byte(1'b1, d); check("R11 high byte", d, 8'hBE);
      rd_byte(1'b1, d); check("R5 id after result", d, 8'h28);
      rd_byte(1'b0, d); check("R6 wrap then nack", d, 8'h99);
      #(4*TCLK);
      check("R6 released after nack", sda_pull, 1'b0);
      bus_stop();
   endtask

   task automatic t_stop_midbyte();
      logic a; int s0;
      s0 = stb_cnt[0];
      set_ptr(8'h00, "R7");
      send_bits(8'hC3, 4);
      bus_stop(); #(4*TCLK);
      check("R7 mode kept", mode, 8'h99);
      check("R7 no strobe", stb_cnt[0] - s0, 0);
      set_ptr(8'h00, "R7");
      wr_byte(8'h01, a); bus_stop(); #(4*TCLK);
      check("R7 next transfer ok", mode, 8'h01);
   endtask

   task automatic t_unimpl();
      logic a; logic [7:0] d;
      set_ptr(8'h05, "R9");
      wr_byte(8'hEE, a); check("R9 data acked", a, 1'b1);
      bus_stop();
      set_ptr(8'h05, "R9");
      bus_start(); wr_byte(8'h89, a); rd_byte(1'b0, d); bus_stop();
      check("R9 hole reads zero", d, 8'h00);
      set_ptr(8'h10, "R9");
      bus_start(); wr_byte(8'h89, a);
      rd_byte(1'b1, d); check("R9 high hole zero", d, 8'h00);
      rd_byte(1'b0, d); check("R9 wraps to 00", d, 8'h01);
      bus_stop(); #(4*TCLK);
      check("R9 mode unchanged", mode, 8'h01);
   endtask

   initial begin
      #(1_200_000ns);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (10) @(posedge clk);
      #1; rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_id_read();
      t_single_write();
      t_bad_addr();
      t_burst_write();
      t_bout_no_set();
      t_burst_read();
      t_stop_midbyte();
      t_unimpl();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule